// File: doc/BRIEF.md
# Round-Robin Rollout Dispatcher and Completion Merger

This block sits between one descriptor queue and a pool of rollout workers. It takes a descriptor from the queue only on a cycle in which at least one worker reports itself idle. It hands that descriptor to one idle worker, chosen fairly by a rotating priority pointer. Each worker runs its own trajectory with a private token counter. While it is busy it reports not idle, so any surplus descriptors stay in the queue until a worker frees up.

On the return side, every worker presents at most one completion record at a time. A second rotating-priority arbiter forwards one of them per cycle onto a single completion stream. When that stream is not ready, no worker is told that its record was taken. A worker that holds a record therefore stays busy and stops taking work. Intake then stops as well, and the descriptor queue fills: back-pressure reaches the queue without any record being lost. Both selected worker indices are brought out for debug.

Top module: `rollout_dispatch_merge`

## Requirements
- R1: `in_ready` is high exactly when at least one bit of `wk_idle` is high. A descriptor is taken on a cycle with `in_valid` and `in_ready` both high, and only then.
- R2: `wk_start` has at most one bit set. A bit is set only when `in_valid` is high and only for a worker whose `wk_idle` bit is high. `wk_desc` carries `in_desc` unchanged.
- R3: Dispatch picks the first idle worker at or after the dispatch pointer, counting upward and wrapping from N-1 to 0. After a descriptor is taken, the pointer becomes (granted index + 1) mod N; otherwise it holds. Reset sets it to worker 0.
- R4: `out_valid` is high exactly when at least one bit of `wk_cmp_valid` is high. `out_data` then equals the record of the worker being forwarded (worker i's record is bits [i*CMP_W +: CMP_W] of `wk_cmp_data`).
- R5: The merge picks the first worker with a valid record at or after the merge pointer, wrapping. The pointer becomes (granted index + 1) mod N only when `out_valid` and `out_ready` are both high. Reset sets it to worker 0.
- R6: While `out_ready` is low, every bit of `wk_cmp_ready` is low. If the valid set is unchanged, the merge selection stays on the same worker in the next cycle.
- R7: `wk_cmp_ready` has at most one bit set, only for a worker with a valid record, and only while `out_ready` is high.
- R8: `dbg_disp_idx` is the index of the worker receiving `wk_start`, and `dbg_merge_idx` is the index of the worker being forwarded. Each is meaningful while its grant exists.
- R9: `N_WORKERS` must lie between 2 and 8 and the data widths must be at least 1; any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Descriptor queue has an entry |
| in_ready | output | 1 | Descriptor taken this cycle when valid |
| in_desc | input | DESC_W | Descriptor at the queue head |
| wk_idle | input | N_WORKERS | Per-worker idle flag |
| wk_start | output | N_WORKERS | One-hot start strobe to the chosen worker |
| wk_desc | output | DESC_W | Descriptor broadcast to the workers |
| wk_cmp_valid | input | N_WORKERS | Per-worker completion record present |
| wk_cmp_data | input | N_WORKERS*CMP_W | Flattened per-worker completion records |
| wk_cmp_ready | output | N_WORKERS | Record taken from this worker |
| out_valid | output | 1 | Merged completion present |
| out_ready | input | 1 | Downstream accepts the merged completion |
| out_data | output | CMP_W | Merged completion record |
| dbg_disp_idx | output | $clog2(N_WORKERS) | Index chosen for dispatch |
| dbg_merge_idx | output | $clog2(N_WORKERS) | Index chosen for merge |

## Verification
The bench drives partly idle worker sets so that the dispatch pointer has to skip busy workers and wrap past N-1. A design that restarted the search at worker 0, or that moved the pointer on an idle cycle with no descriptor, would pick the wrong worker. It also withholds `out_ready` for several cycles while all workers hold records. A merger that leaked a ready pulse would drop a record, and one that rotated while stalled would break fairness. A mid-run reset then checks that both pointers return to worker 0, and a cycle with every worker busy checks that no descriptor is taken.

// File: rtl/dm_pkg.sv
package dm_pkg;
   localparam int MIN_WORKERS = 2;
   localparam int MAX_WORKERS = 8;

   // width of a worker index for a pool of n workers
   function automatic int idx_w(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/rr_pick.sv
// Rotating-priority picker: grants the first requester at or after the
// pointer; the pointer moves past the winner only when the grant is used.
module rr_pick
   import dm_pkg::*;
#(
   parameter int N = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [N-1:0]          req,
   input  logic                  adv,
   output logic [N-1:0]          gnt,
   output logic [idx_w(N)-1:0]   gnt_idx,
   output logic                  any
);
   localparam int IW = idx_w(N);

   logic [IW-1:0] ptr;
   logic [IW:0]   cand;
   logic          found;

   always_comb begin
      found   = 1'b0;
      gnt_idx = '0;
      cand    = '0;
      for (int k = 0; k < N; k++) begin
         cand = {1'b0, ptr} + (IW+1)'(k);
         if (cand >= (IW+1)'(N)) cand = cand - (IW+1)'(N);
         if (!found && req[cand[IW-1:0]]) begin
            found   = 1'b1;
            gnt_idx = cand[IW-1:0];
         end
      end
      gnt = '0;
      if (found) gnt[gnt_idx] = 1'b1;
      any = found;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (adv && found) begin
         ptr <= (gnt_idx == IW'(N-1)) ? '0 : gnt_idx + 1'b1;
      end
   end
endmodule

// File: rtl/onehot_mux.sv
// AND-OR selector driven by a one-hot select vector.
module onehot_mux #(
   parameter int N = 4,
   parameter int W = 16
) (
   input  logic [N-1:0]   sel,
   input  logic [N*W-1:0] din,
   output logic [W-1:0]   dout
);
   logic [W-1:0] lane [N];

   for (genvar i = 0; i < N; i++) begin : g_lane
      assign lane[i] = din[i*W +: W] & {W{sel[i]}};
   end

   always_comb begin
      dout = '0;
      for (int i = 0; i < N; i++) dout = dout | lane[i];
   end
endmodule

// File: rtl/rollout_dispatch_merge.sv
module rollout_dispatch_merge
   import dm_pkg::*;
#(
   parameter int N_WORKERS = 4,
   parameter int DESC_W    = 32,
   parameter int CMP_W     = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_valid,
   output logic                          in_ready,
   input  logic [DESC_W-1:0]             in_desc,
   input  logic [N_WORKERS-1:0]          wk_idle,
   output logic [N_WORKERS-1:0]          wk_start,
   output logic [DESC_W-1:0]             wk_desc,
   input  logic [N_WORKERS-1:0]          wk_cmp_valid,
   input  logic [N_WORKERS*CMP_W-1:0]    wk_cmp_data,
   output logic [N_WORKERS-1:0]          wk_cmp_ready,
   output logic                          out_valid,
   input  logic                          out_ready,
   output logic [CMP_W-1:0]              out_data,
   output logic [idx_w(N_WORKERS)-1:0]   dbg_disp_idx,
   output logic [idx_w(N_WORKERS)-1:0]   dbg_merge_idx
);
   localparam int IW = idx_w(N_WORKERS);

   // R9: elaboration-time parameter checks
   if (N_WORKERS < MIN_WORKERS || N_WORKERS > MAX_WORKERS) begin : g_bad_n
      $error("rollout_dispatch_merge: N_WORKERS out of range");
   end
   if (DESC_W < 1 || CMP_W < 1) begin : g_bad_w
      $error("rollout_dispatch_merge: data widths must be positive");
   end

   logic [N_WORKERS-1:0] d_gnt, m_gnt;
   logic                 d_any, m_any;
   logic [IW-1:0]        d_idx, m_idx;

   // dispatch side: idle workers request, a taken descriptor advances
   rr_pick #(.N(N_WORKERS)) u_disp (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (wk_idle),
      .adv     (in_valid),
      .gnt     (d_gnt),
      .gnt_idx (d_idx),
      .any     (d_any)
   );

   assign in_ready     = d_any;
   assign wk_start     = d_gnt & {N_WORKERS{in_valid}};
   assign wk_desc      = in_desc;
   assign dbg_disp_idx = d_idx;

   // merge side: valid records request, a downstream accept advances
   rr_pick #(.N(N_WORKERS)) u_merge (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (wk_cmp_valid),
      .adv     (out_ready),
      .gnt     (m_gnt),
      .gnt_idx (m_idx),
      .any     (m_any)
   );

   onehot_mux #(.N(N_WORKERS), .W(CMP_W)) u_cmux (
      .sel  (m_gnt),
      .din  (wk_cmp_data),
      .dout (out_data)
   );

   assign out_valid     = m_any;
   assign wk_cmp_ready  = m_gnt & {N_WORKERS{out_ready}};
   assign dbg_merge_idx = m_idx;
endmodule

// File: rtl/rollout_dispatch_merge_chk.sv
module rollout_dispatch_merge_chk
   import dm_pkg::*;
#(
   parameter int N_WORKERS = 4,
   parameter int DESC_W    = 32,
   parameter int CMP_W     = 16
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          in_valid,
   input logic                          in_ready,
   input logic [DESC_W-1:0]             in_desc,
   input logic [N_WORKERS-1:0]          wk_idle,
   input logic [N_WORKERS-1:0]          wk_start,
   input logic [DESC_W-1:0]             wk_desc,
   input logic [N_WORKERS-1:0]          wk_cmp_valid,
   input logic [N_WORKERS*CMP_W-1:0]    wk_cmp_data,
   input logic [N_WORKERS-1:0]          wk_cmp_ready,
   input logic                          out_valid,
   input logic                          out_ready,
   input logic [CMP_W-1:0]              out_data,
   input logic [idx_w(N_WORKERS)-1:0]   dbg_disp_idx,
   input logic [idx_w(N_WORKERS)-1:0]   dbg_merge_idx
);
   AST_READY_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> (wk_idle != '0)); // R1
   AST_TAKE_STARTS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |-> $countones(wk_start) == 1); // R1
   AST_START_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wk_start)); // R2
   AST_START_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (wk_start & ~wk_idle) == '0); // R2
   AST_DESC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (wk_start != '0) |-> wk_desc == in_desc); // R2
   AST_OUT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == (wk_cmp_valid != '0)); // R4
   AST_STALL_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
      !out_ready |-> wk_cmp_ready == '0); // R6
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) ##1 $stable(wk_cmp_valid) |-> $stable(dbg_merge_idx)); // R6
   AST_CRDY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wk_cmp_ready) && ((wk_cmp_ready & ~wk_cmp_valid) == '0)); // R7
   AST_DBG_DISP: assert property (@(posedge clk) disable iff (!rst_n)
      (wk_start != '0) |-> wk_start[dbg_disp_idx]); // R8
   AST_DBG_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
      (wk_cmp_ready != '0) |-> wk_cmp_ready[dbg_merge_idx]); // R8
endmodule

bind rollout_dispatch_merge rollout_dispatch_merge_chk #(
   .N_WORKERS(N_WORKERS), .DESC_W(DESC_W), .CMP_W(CMP_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .in_desc(in_desc), .wk_idle(wk_idle), .wk_start(wk_start), .wk_desc(wk_desc),
   .wk_cmp_valid(wk_cmp_valid), .wk_cmp_data(wk_cmp_data),
   .wk_cmp_ready(wk_cmp_ready), .out_valid(out_valid), .out_ready(out_ready),
   .out_data(out_data), .dbg_disp_idx(dbg_disp_idx), .dbg_merge_idx(dbg_merge_idx)
);

// File: tb/rollout_dispatch_merge_test.sv
`timescale 1ns/1ps
module rollout_dispatch_merge_test;
   localparam int NW = 4;
   localparam int DW = 32;
   localparam int CW = 16;
   localparam int NV = 17;

   // vector: in_valid, idle[4], cmp_valid[4], out_ready |
   //         exp in_ready, start[4], disp_idx[2], out_valid, cmp_ready[4], merge_idx[2]
   localparam logic [23:0] VEC [NV] = '{
      24'b1_1111_0000_1_1_0001_00_0_0000_00,
      24'b1_1111_0000_1_1_0010_01_0_0000_00,
      24'b1_1011_0000_1_1_1000_11_0_0000_00,
      24'b0_0001_0000_1_1_0000_00_0_0000_00,
      24'b1_0000_0000_1_0_0000_00_0_0000_00,
      24'b1_0100_0000_1_1_0100_10_0_0000_00,
      24'b1_0011_0000_1_1_0001_00_0_0000_00,
      24'b0_0000_1111_1_0_0000_00_1_0001_00,
      24'b0_0000_1111_0_0_0000_00_1_0000_01,
      24'b0_0000_1111_0_0_0000_00_1_0000_01,
      24'b0_0000_1111_1_0_0000_00_1_0010_01,
      24'b0_0000_1001_1_0_0000_00_1_1000_11,
      24'b0_0000_1001_1_0_0000_00_1_0001_00,
      24'b0_0000_0000_1_0_0000_00_0_0000_00,
      24'b0_0000_1000_1_0_0000_00_1_1000_11,
      24'b1_0110_0110_1_1_0010_01_1_0010_01,
      24'b1_0110_0110_0_1_0100_10_1_0000_10
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [DW-1:0] in_desc = '0;
   logic [NW-1:0] wk_idle = '0;
   logic [NW-1:0] wk_start;
   logic [DW-1:0] wk_desc;
   logic [NW-1:0] wk_cmp_valid = '0;
   logic [NW*CW-1:0] wk_cmp_data = {16'hC003, 16'hC002, 16'hC001, 16'hC000};
   logic [NW-1:0] wk_cmp_ready;
   logic          out_valid;
   logic          out_ready = 1'b0;
   logic [CW-1:0] out_data;
   logic [1:0]    dbg_disp_idx, dbg_merge_idx;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   rollout_dispatch_merge #(.N_WORKERS(NW), .DESC_W(DW), .CMP_W(CW)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_desc(in_desc), .wk_idle(wk_idle), .wk_start(wk_start), .wk_desc(wk_desc),
      .wk_cmp_valid(wk_cmp_valid), .wk_cmp_data(wk_cmp_data),
      .wk_cmp_ready(wk_cmp_ready), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .dbg_disp_idx(dbg_disp_idx), .dbg_merge_idx(dbg_merge_idx)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input logic iv, input logic [3:0] idle,
                        input logic [3:0] cv, input logic ordy);
      in_valid     = iv;
      wk_idle      = idle;
      wk_cmp_valid = cv;
      out_ready    = ordy;
   endtask

   initial begin
      // reset state (R3, R5): both pointers start at worker 0
      drive(1'b0, 4'b1111, 4'b1111, 1'b0);
      repeat (3) @(posedge clk);
      @(negedge clk); #1;
      chk("R3 reset disp idx", 32'(dbg_disp_idx), 0);
      chk("R5 reset merge idx", 32'(dbg_merge_idx), 0);
      rst_n = 1'b1;

      // table walk, covers R1..R8 (R9 is an elaboration check)
      for (int v = 0; v < NV; v++) begin
         logic [23:0] e;
         @(negedge clk);
         e = VEC[v];
         in_desc = 32'hD000_0000 + 32'(v);
         drive(e[23], e[22:19], e[18:15], e[14]);
         #1;
         chk($sformatf("R1 in_ready v%0d", v), 32'(in_ready), 32'(e[13]));
         chk($sformatf("R2 wk_start v%0d", v), 32'(wk_start), 32'(e[12:9]));
         chk($sformatf("R2 wk_desc v%0d", v), wk_desc, in_desc);
         if (e[12:9] != 4'b0000)
            chk($sformatf("R3 R8 disp idx v%0d", v), 32'(dbg_disp_idx), 32'(e[8:7]));
         chk($sformatf("R4 out_valid v%0d", v), 32'(out_valid), 32'(e[6]));
         if (e[14])
            chk($sformatf("R7 wk_cmp_ready v%0d", v), 32'(wk_cmp_ready), 32'(e[5:2]));
         else
            chk($sformatf("R6 wk_cmp_ready v%0d", v), 32'(wk_cmp_ready), 32'(e[5:2]));
         if (e[6]) begin
            chk($sformatf("R5 R8 merge idx v%0d", v), 32'(dbg_merge_idx), 32'(e[1:0]));
            chk($sformatf("R4 out_data v%0d", v), 32'(out_data), 32'(16'hC000 + 16'(e[1:0])));
         end
      end

      // pointers now: dispatch at 3, merge held at 2 by the last stall
      @(negedge clk);
      drive(1'b0, 4'b1111, 4'b1111, 1'b0);
      #1;
      chk("R3 pointer after table", 32'(dbg_disp_idx), 3);
      chk("R6 merge held during stall", 32'(dbg_merge_idx), 2);

      // mid-run reset returns both pointers to worker 0 (R3, R5)
      rst_n = 1'b0;
      #1;
      chk("R3 mid-run reset disp idx", 32'(dbg_disp_idx), 0);
      chk("R5 mid-run reset merge idx", 32'(dbg_merge_idx), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // wrap from the last worker back to worker 0 (R3)
      @(negedge clk);
      drive(1'b1, 4'b1000, 4'b0000, 1'b1);
      #1;
      chk("R3 grant last worker", 32'(wk_start), 32'b1000);
      @(negedge clk);
      drive(1'b1, 4'b1001, 4'b0000, 1'b1);
      #1;
      chk("R3 wrap to worker 0", 32'(wk_start), 32'b0001);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule